// File: doc/BRIEF.md
# Gated Event Counter with Edge-Sensed Interrupt

This block counts external events in a 16-bit value built from two cascaded 8-bit stages. Counting is allowed only while a shared gate signal is high. A control bit picks where the gate comes from: a synchronized external pin, or a PWM level produced elsewhere on the chip. Because both stages share the one gate, an external agent or a periodic waveform can start and stop the whole count window. Neither stage can be held on its own.

The same gate signal also drives an edge detector. The detector can be set to sense falling edges, rising edges, or both. A sensed edge sets a sticky request flag. Software clears the flag by writing zero to it. An enable bit masks the flag before it leaves the block as the interrupt line. Control settings and flag clears arrive as single-cycle write strobes.

Top module: `gated_event_counter`

## Requirements
- R1: When the source bit is 0, the synchronized pin is the gate. A synchronized rising edge on `event_i` advances the count only while the pin is high.
- R2: When the source bit is 1, `pwm_i` is the gate. It is used as-is, with no synchronizer.
- R3: While the selected gate is low, neither stage changes, whatever `event_i` does.
- R4: The low stage wraps from 0xFF to 0x00, and its carry increments the high stage. The combined value wraps from 0xFFFF to 0x0000.
- R5: Edge-select code 2'b00 senses falling edges of the gate only.
- R6: Edge-select code 2'b01 senses rising edges of the gate only.
- R7: Edge-select codes 2'b10 and 2'b11 sense both edges of the gate.
- R8: The request flag stays set until a flag write with data 0. A flag write with data 1 has no effect. If an edge is sensed in the same cycle as a clear, the flag stays set.
- R9: `irq_o` is high exactly when the flag is 1 and the enable bit is 1. A change to either one shows on `irq_o` in the same cycle as the change.
- R10: A write to the control register reloads the detector's previous sample from the newly selected source. Switching the source therefore never sets the flag by itself.
- R11: A synchronous reset clears both stages, the flag, `irq_o`, the enable bit, the source bit and the edge-select field.
- R12: `event_i` and `gate_pin_i` each pass through a two-flop synchronizer before they are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_i | input | 1 | Asynchronous event input; counted on its rising edge |
| gate_pin_i | input | 1 | Asynchronous external gate pin |
| pwm_i | input | 1 | On-chip PWM gate level |
| ctrl_we_i | input | 1 | Write strobe for the control fields below |
| ctrl_src_i | input | 1 | Gate source: 0 selects the pin, 1 selects the PWM |
| ctrl_edge_i | input | 2 | Edge sense: 00 falling, 01 rising, 1x both |
| ctrl_irq_en_i | input | 1 | Interrupt enable |
| flag_we_i | input | 1 | Write strobe for the request flag |
| flag_wdata_i | input | 1 | Flag write data; only 0 has an effect |
| cnt_lo_o | output | 8 | Low count stage |
| cnt_hi_o | output | 8 | High count stage |
| flag_o | output | 1 | Sticky edge request flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The event input is toggled with the pin gate held high, held low, and switched part-way through a burst. This shows whether counting follows the gate and whether the low stage and the high stage stay frozen together. The same bursts are repeated with the PWM as the source while the pin is driven opposite to it, which exposes a wrong source mux. The gate is toggled under each edge-select code to separate falling, rising and both-edge sensing. A clear is timed to land in the same cycle as a sensed edge, and the source is switched between two sources at different levels, to check flag priority and the absence of a spurious edge. A long burst of about 65,540 events drives the count through the carry at 0x00FF and the full wrap at 0xFFFF.

// File: rtl/gated_event_counter_pkg.sv
package gated_event_counter_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10
  } edge_sel_e;
endpackage

// File: rtl/gec_sync.sv
module gec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= '0;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gec_cascade.sv
module gec_cascade #(
  parameter int STAGE_W    = 8,
  parameter int NUM_STAGES = 2,
  localparam int TOTAL_W   = STAGE_W * NUM_STAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gate_i,
  input  logic               tick_i,
  output logic [TOTAL_W-1:0] cnt_o
);
  logic [NUM_STAGES:0] carry;
  assign carry[0] = gate_i & tick_i;

  genvar g;
  generate
    for (g = 0; g < NUM_STAGES; g++) begin : g_cnt
      logic [STAGE_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (rst)           val_q <= '0;
        else if (carry[g]) val_q <= val_q + 1'b1;
      end
      assign carry[g+1] = carry[g] & (&val_q);
      assign cnt_o[g*STAGE_W +: STAGE_W] = val_q;
    end
  endgenerate

  assert_hold_when_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !gate_i |=> $stable(cnt_o));
  assert_step_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (gate_i && tick_i) |=> cnt_o == TOTAL_W'($past(cnt_o) + 1'b1));
  assert_idle_no_tick_R1: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/gec_edge_flag.sv
module gec_edge_flag
  import gated_event_counter_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      gate_i,
  input  edge_sel_e edge_sel_i,
  input  logic      resample_i,
  input  logic      resample_val_i,
  input  logic      clr_i,
  output logic      flag_o,
  output logic      flag_next_o
);
  logic prev_q;
  logic rise, fall, hit;

  assign rise = gate_i & ~prev_q;
  assign fall = ~gate_i & prev_q;

  always_comb begin
    case (edge_sel_i)
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      default:   hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             prev_q <= 1'b0;
    else if (resample_i) prev_q <= resample_val_i;
    else                 prev_q <= gate_i;
  end

  always_comb begin
    if (hit)        flag_next_o = 1'b1;
    else if (clr_i) flag_next_o = 1'b0;
    else            flag_next_o = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= flag_next_o;
  end

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && hit) |=> flag_o);
  assert_fall_only_R5: assert property (@(posedge clk) disable iff (rst)
    (edge_sel_i == EDGE_FALL && rise && !flag_o) |=> !flag_o);
  assert_rise_only_R6: assert property (@(posedge clk) disable iff (rst)
    (edge_sel_i == EDGE_RISE && fall && !flag_o) |=> !flag_o);
endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter
  import gated_event_counter_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             event_i,
  input  logic             gate_pin_i,
  input  logic             pwm_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_src_i,
  input  logic [1:0]       ctrl_edge_i,
  input  logic             ctrl_irq_en_i,
  input  logic             flag_we_i,
  input  logic             flag_wdata_i,
  output logic [CNT_W-1:0] cnt_lo_o,
  output logic [CNT_W-1:0] cnt_hi_o,
  output logic             flag_o,
  output logic             irq_o
);
  localparam int NUM_STAGES = 2;
  localparam int TOTAL_W    = CNT_W * NUM_STAGES;

  logic            ev_s, pin_s, ev_d, ev_rise;
  logic            src_q, en_q, en_next;
  edge_sel_e       edge_q;
  logic            gate;
  logic            flag_next;
  logic [TOTAL_W-1:0] cnt;

  gec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({event_i, gate_pin_i}),
    .q_o ({ev_s, pin_s})
  );

  always_ff @(posedge clk) begin
    if (rst) ev_d <= 1'b0;
    else     ev_d <= ev_s;
  end
  assign ev_rise = ev_s & ~ev_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= 1'b0;
      en_q   <= 1'b0;
      edge_q <= EDGE_FALL;
    end else if (ctrl_we_i) begin
      src_q  <= ctrl_src_i;
      en_q   <= ctrl_irq_en_i;
      edge_q <= edge_sel_e'(ctrl_edge_i);
    end
  end

  assign gate    = src_q ? pwm_i : pin_s;
  assign en_next = ctrl_we_i ? ctrl_irq_en_i : en_q;

  gec_cascade #(.STAGE_W(CNT_W), .NUM_STAGES(NUM_STAGES)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .gate_i (gate),
    .tick_i (ev_rise),
    .cnt_o  (cnt)
  );

  gec_edge_flag u_edge (
    .clk            (clk),
    .rst            (rst),
    .gate_i         (gate),
    .edge_sel_i     (edge_q),
    .resample_i     (ctrl_we_i),
    .resample_val_i (ctrl_src_i ? pwm_i : pin_s),
    .clr_i          (flag_we_i & ~flag_wdata_i),
    .flag_o         (flag_o),
    .flag_next_o    (flag_next)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= flag_next & en_next;
  end

  assign cnt_lo_o = cnt[CNT_W-1:0];
  assign cnt_hi_o = cnt[TOTAL_W-1:CNT_W];

  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_o && en_q));
  assert_no_switch_edge_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we_i && !flag_o && !(flag_we_i && !flag_wdata_i) && src_q == ctrl_src_i
     && $stable(gate)) |=> !flag_o || $past(gate) != $past(gate, 2));
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !flag_o && !irq_o && !src_q && !en_q));
endmodule

// File: tb/test_gated_event_counter.sv
module test_gated_event_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic event_i = 0, gate_pin_i = 0, pwm_i = 0;
  logic ctrl_we_i = 0, ctrl_src_i = 0, ctrl_irq_en_i = 0;
  logic [1:0] ctrl_edge_i = 2'b00;
  logic flag_we_i = 0, flag_wdata_i = 0;
  logic [7:0] cnt_lo_o, cnt_hi_o;
  logic flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R11";

  always #2 clk = ~clk;

  gated_event_counter i_gated_event_counter (
    .clk(clk), .rst(rst), .event_i(event_i), .gate_pin_i(gate_pin_i),
    .pwm_i(pwm_i), .ctrl_we_i(ctrl_we_i), .ctrl_src_i(ctrl_src_i),
    .ctrl_edge_i(ctrl_edge_i), .ctrl_irq_en_i(ctrl_irq_en_i),
    .flag_we_i(flag_we_i), .flag_wdata_i(flag_wdata_i),
    .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // Behavioural reference model
  int m_cnt = 0;
  bit m_ev1, m_ev2, m_evd, m_pin1, m_pin2, m_prev, m_sel, m_en, m_flag, m_irq;
  bit [1:0] m_edge;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; m_ev1 = 0; m_ev2 = 0; m_evd = 0; m_pin1 = 0; m_pin2 = 0;
      m_prev = 0; m_sel = 0; m_en = 0; m_flag = 0; m_irq = 0; m_edge = 0;
    end else begin
      bit g, hit, r, f;
      g = m_sel ? pwm_i : m_pin2;
      r = g && !m_prev;
      f = !g && m_prev;
      hit = (m_edge == 2'b00) ? f : (m_edge == 2'b01) ? r : (r || f);
      if (m_ev2 && !m_evd && g) m_cnt = (m_cnt + 1) % 65536;
      if (hit) m_flag = 1;
      else if (flag_we_i && !flag_wdata_i) m_flag = 0;
      if (ctrl_we_i) begin
        m_sel = ctrl_src_i; m_en = ctrl_irq_en_i; m_edge = ctrl_edge_i;
        m_prev = ctrl_src_i ? pwm_i : m_pin2;
      end else m_prev = g;
      m_irq = m_flag && m_en;
      m_evd = m_ev2; m_ev2 = m_ev1; m_ev1 = event_i;
      m_pin2 = m_pin1; m_pin1 = gate_pin_i;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check("count", {cnt_hi_o, cnt_lo_o}, m_cnt);
    check("flag", flag_o, m_flag);
    check("irq", irq_o, m_irq);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_ctrl(bit src, bit [1:0] edg, bit en);
    ctrl_we_i = 1; ctrl_src_i = src; ctrl_edge_i = edg; ctrl_irq_en_i = en;
    step(1);
    ctrl_we_i = 0;
  endtask

  task automatic clear_flag(bit d);
    flag_we_i = 1; flag_wdata_i = d;
    step(1);
    flag_we_i = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      event_i = 1; step(1);
      event_i = 0; step(1);
    end
  endtask

  initial begin
    step(3);
    rst = 0;
    phase = "R11"; step(2);
    // R1: pin gate
    phase = "R1";
    set_ctrl(0, 2'b01, 1);
    gate_pin_i = 1; step(4);
    pulses(10);
    // R3: gate low holds both stages
    phase = "R3";
    gate_pin_i = 0; step(4);
    pulses(10);
    // R12: pin flips mid-burst, sync latency visible
    phase = "R12";
    fork
      pulses(8);
      begin step(5); gate_pin_i = 1; end
    join
    // R2: pwm gate, pin opposite
    phase = "R2";
    set_ctrl(1, 2'b01, 1);
    clear_flag(0);
    pwm_i = 0; gate_pin_i = 1; step(4);
    pulses(6);
    pwm_i = 1; gate_pin_i = 0; step(4);
    pulses(6);
    // R6 rising only
    phase = "R6";
    clear_flag(0);
    pwm_i = 0; step(3);
    check("R6 no set on fall", flag_o, 0);
    pwm_i = 1; step(3);
    // R5 falling only
    phase = "R5";
    set_ctrl(1, 2'b00, 1);
    clear_flag(0);
    pwm_i = 1; step(2);
    pwm_i = 0; step(1); pwm_i = 1; step(2);
    // R8: write 1 ignored, clear, and set wins
    phase = "R8";
    clear_flag(1);
    check("R8 write 1 ignored", flag_o, 1);
    clear_flag(0);
    check("R8 cleared", flag_o, 0);
    pwm_i = 0; flag_we_i = 1; flag_wdata_i = 0; step(1); flag_we_i = 0;
    check("R8 set wins", flag_o, 1);
    // R9: mask
    phase = "R9";
    set_ctrl(1, 2'b00, 0);
    check("R9 masked", irq_o, 0);
    set_ctrl(1, 2'b00, 1);
    check("R9 unmasked", irq_o, 1);
    // R7 both edges, codes 10 and 11
    phase = "R7";
    for (int c = 2; c < 4; c++) begin
      set_ctrl(1, 2'(c), 1);
      clear_flag(0);
      pwm_i = 1; step(2); clear_flag(0);
      pwm_i = 0; step(2);
    end
    // R10: switch source between different levels
    phase = "R10";
    gate_pin_i = 1; pwm_i = 0; set_ctrl(0, 2'b10, 1); step(4);
    clear_flag(0);
    set_ctrl(1, 2'b10, 1); step(2);
    check("R10 no spurious edge", flag_o, 0);
    set_ctrl(0, 2'b10, 1); step(2);
    check("R10 no spurious edge back", flag_o, 0);
    // R4: carry and full wrap
    phase = "R4";
    gate_pin_i = 1; step(3);
    pulses(65540);
    step(4);
    // R11: reset clears everything
    phase = "R11";
    rst = 1; step(2);
    check("R11 count", {cnt_hi_o, cnt_lo_o}, 0);
    rst = 0; step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 195000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule